// File: doc/BRIEF.md
# Raster Scan-Out Display Controller

This block drives a fixed 640x480 true-colour panel or a VGA connector from a framebuffer in external memory. A host programs two 32-bit registers: the framebuffer base address and a control word. The control word holds an enable bit and a 180-degree rotation bit. A free-running raster generator produces the line and frame timing. While the display is enabled and the raster is inside the visible window, the block issues one word read per pixel to a simple request/response memory port. It unpacks each returned word into 8-bit red, green and blue and drives them out with a data-enable strobe and two active-low sync pulses.

The base register keeps only its upper 11 bits, so the framebuffer sits on a 2 MiB boundary. Each raster row occupies 1024 words of memory, and only the first 640 of those words are fetched. A host write lands in a pending copy of the register. The copy that drives the scan is refreshed only on the last cycle of vertical blanking, so a frame always shows one consistent configuration.

Top module: `scanout_ctrl`

## Requirements
- R1: After reset both registers read back as zero, the display is disabled, no memory request is made, data-enable is low and the colour outputs are zero.
- R2: The register index is the byte offset divided by four: offset 0 is the base register and offset 4 is the control register. A read of the base register returns the written value with bits 20:0 cleared. A read of the control register returns bit 0 (enable) and bit 1 (rotate), with all other bits zero. Writes to any other offset change nothing, and reads there return zero.
- R3: With rotation off, pixels are fetched in raster order. The pixel at (row, col) is read from word address (base[31:21] << 19) + row*1024 + col.
- R4: With rotation on, the pixel shown at (row, col) is read from word address (base[31:21] << 19) + (479-row)*1024 + (639-col).
- R5: The colour outputs take red from word bits 23:16, green from bits 15:8 and blue from bits 7:0. Bits 31:24 have no effect.
- R6: While the active enable bit is clear, no memory request is issued and data-enable stays low. Both sync outputs keep their normal timing.
- R7: A line lasts 800 cycles, with hsync_n low for 96 of them. A frame lasts 525 lines, with vsync_n low for 2 lines. Each frame has 480 lines of 640 data-enabled pixels.
- R8: A register write takes effect at the first pixel of the next frame. The frame in progress completes with the configuration it started with.
- R9: Read data is taken exactly MEM_LAT cycles after its request. Data-enable, syncs and colour leave the block mutually aligned.
- R10: The colour outputs are zero whenever data-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request, one per pixel |
| mem_addr | output | 30 | Word address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| px_red | output | 8 | Red level |
| px_green | output | 8 | Green level |
| px_blue | output | 8 | Blue level |
| px_de | output | 1 | Data enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The alignment check assumes that the memory answers every request with a valid word exactly MEM_LAT cycles later and never stalls. The bench model therefore is a plain MEM_LAT-deep delay line on the request and address. The address-step and window checks assume that the configuration cannot change between two back-to-back requests. The stimulus respects this by writing registers only mid-frame, after the first visible pixel, or in the back porch right after the sync pulse. That places every change on a frame wrap, away from any fetch run.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  typedef struct packed {
    logic de;
    logic hs_n;
    logic vs_n;
  } vid_ctl_t;

  localparam vid_ctl_t VID_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

  // Word offset of the pixel shown at (row, col) inside the framebuffer.
  function automatic int unsigned raster_offset(
    input int unsigned row,
    input int unsigned col,
    input int unsigned rows,
    input int unsigned cols,
    input int unsigned stride_log2,
    input logic        rot
  );
    int unsigned r;
    int unsigned c;
    r = rot ? (rows - 1 - row) : row;
    c = rot ? (cols - 1 - col) : col;
    return (r << stride_log2) + c;
  endfunction

endpackage

// File: rtl/scanout_regs.sv
module scanout_regs #(
  parameter int ADDR_W    = 32,
  parameter int BASE_KEEP = 11,
  parameter int REG_AW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [ADDR_W-1:0]    wdata,
  output logic [ADDR_W-1:0]    rdata,
  input  logic                 frame_start,
  output logic                 cfg_en,
  output logic                 cfg_rot,
  output logic [BASE_KEEP-1:0] cfg_base_hi
);
  localparam int BASE_LO = ADDR_W - BASE_KEEP;

  logic                 hit_base, hit_ctrl;
  logic [BASE_KEEP-1:0] pend_base;
  logic                 pend_en, pend_rot;
  logic                 unused_wbits;

  assign hit_base     = (reg_addr == REG_AW'(0));
  assign hit_ctrl     = (reg_addr == REG_AW'(4));
  assign unused_wbits = ^wdata[BASE_LO-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_base <= '0;
      pend_en   <= 1'b0;
      pend_rot  <= 1'b0;
    end else if (wr_en) begin
      if (hit_base) pend_base <= wdata[ADDR_W-1:BASE_LO];
      if (hit_ctrl) begin
        pend_en  <= wdata[0];
        pend_rot <= wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_base_hi <= '0;
      cfg_en      <= 1'b0;
      cfg_rot     <= 1'b0;
    end else if (frame_start) begin
      cfg_base_hi <= pend_base;
      cfg_en      <= pend_en;
      cfg_rot     <= pend_rot;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_base) rdata = {pend_base, {BASE_LO{1'b0}}};
    else if (hit_ctrl) rdata = {{(ADDR_W-2){1'b0}}, pend_rot, pend_en};
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cfg_en) && $stable(cfg_rot) && $stable(cfg_base_hi))); // R8

endmodule

// File: rtl/scanout_timing.sv
module scanout_timing #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          in_active,
  output logic          hs_raw_n,
  output logic          vs_raw_n,
  output logic          frame_start
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;

  logic line_end;

  assign line_end    = (h_cnt == HW'(H_TOT - 1));
  assign frame_start = line_end && (v_cnt == VW'(V_TOT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (line_end) begin
      h_cnt <= '0;
      v_cnt <= frame_start ? '0 : v_cnt + VW'(1);
    end else begin
      h_cnt <= h_cnt + HW'(1);
    end
  end

  assign in_active = (h_cnt < HW'(H_ACT)) && (v_cnt < VW'(V_ACT));
  assign hs_raw_n  = !((h_cnt >= HW'(H_ACT + H_FP)) && (h_cnt < HW'(H_ACT + H_FP + H_SYNC)));
  assign vs_raw_n  = !((v_cnt >= VW'(V_ACT + V_FP)) && (v_cnt < VW'(V_ACT + V_FP + V_SYNC)));

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (h_cnt == '0 && v_cnt == '0)); // R7
  AST_H_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(h_cnt) < H_TOT) && (32'(v_cnt) < V_TOT)); // R7

endmodule

// File: rtl/scanout_fetch.sv
module scanout_fetch
  import scanout_pkg::*;
#(
  parameter int H_ACT       = 640,
  parameter int V_ACT       = 480,
  parameter int HW          = 10,
  parameter int VW          = 10,
  parameter int STRIDE_LOG2 = 10,
  parameter int BASE_KEEP   = 11,
  parameter int MEM_AW      = 30,
  parameter int MEM_LAT     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HW-1:0]        h_cnt,
  input  logic [VW-1:0]        v_cnt,
  input  logic                 in_active,
  input  logic                 hs_raw_n,
  input  logic                 vs_raw_n,
  input  logic                 cfg_en,
  input  logic                 cfg_rot,
  input  logic [BASE_KEEP-1:0] cfg_base_hi,
  output logic                 mem_req,
  output logic [MEM_AW-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [31:0]          mem_rdata,
  output logic [23:0]          px_rgb,
  output logic                 px_de,
  output logic                 hsync_n,
  output logic                 vsync_n
);
  localparam int OFF_W = MEM_AW - BASE_KEEP;

  logic             fetch_now;
  logic [OFF_W-1:0] next_off;
  logic             req_rot;
  vid_ctl_t         head;
  vid_ctl_t         aligned;
  logic             unused_top;

  assign fetch_now  = in_active && cfg_en;
  assign next_off   = OFF_W'(raster_offset(32'(v_cnt), 32'(h_cnt), V_ACT, H_ACT,
                                           STRIDE_LOG2, cfg_rot));
  assign head       = '{de: fetch_now, hs_n: hs_raw_n, vs_n: vs_raw_n};
  assign unused_top = ^mem_rdata[31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      req_rot  <= 1'b0;
    end else begin
      mem_req  <= fetch_now;
      mem_addr <= {cfg_base_hi, next_off};
      req_rot  <= cfg_rot;
    end
  end

  // Timing controls travel alongside the memory read: one request stage plus MEM_LAT.
  for (genvar i = 0; i <= MEM_LAT; i++) begin : g_stg
    vid_ctl_t d;
    vid_ctl_t q;
    if (i == 0) begin : g_head
      assign d = head;
    end else begin : g_tail
      assign d = g_stg[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= VID_IDLE;
      else        q <= d;
    end
  end

  assign aligned = g_stg[MEM_LAT].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_rgb  <= '0;
      px_de   <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      px_rgb  <= aligned.de ? mem_rdata[23:0] : 24'h0;
      px_de   <= aligned.de;
      hsync_n <= aligned.hs_n;
      vsync_n <= aligned.vs_n;
    end
  end

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cfg_en); // R6
  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((32'(mem_addr[STRIDE_LOG2-1:0]) < H_ACT) &&
                 (32'(mem_addr[OFF_W-1:STRIDE_LOG2]) < V_ACT))); // R3
  AST_REQ_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && !req_rot) |-> (mem_addr == $past(mem_addr) + MEM_AW'(1))); // R3
  AST_REQ_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && req_rot) |-> (mem_addr == $past(mem_addr) - MEM_AW'(1))); // R4
  AST_RESP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    aligned.de |-> mem_rvalid); // R9
  AST_BLACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !px_de |-> (px_rgb == 24'h0)); // R10
  AST_SYNC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> !px_de); // R7

endmodule

// File: rtl/scanout_ctrl.sv
module scanout_ctrl #(
  parameter int H_ACT       = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_ACT       = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33,
  parameter int STRIDE_LOG2 = 10,
  parameter int BASE_KEEP   = 11,
  parameter int MEM_LAT     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [29:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  px_red,
  output logic [7:0]  px_green,
  output logic [7:0]  px_blue,
  output logic        px_de,
  output logic        hsync_n,
  output logic        vsync_n
);
  localparam int ADDR_W = 32;
  localparam int MEM_AW = ADDR_W - 2;
  localparam int H_TOT  = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW     = $clog2(H_TOT);
  localparam int VW     = $clog2(V_TOT);

  logic [HW-1:0]        h_cnt;
  logic [VW-1:0]        v_cnt;
  logic                 in_active, hs_raw_n, vs_raw_n, frame_start;
  logic                 cfg_en, cfg_rot;
  logic [BASE_KEEP-1:0] cfg_base_hi;
  logic [23:0]          px_rgb;

  scanout_regs #(.ADDR_W(ADDR_W), .BASE_KEEP(BASE_KEEP), .REG_AW(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .reg_addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_start(frame_start),
    .cfg_en(cfg_en), .cfg_rot(cfg_rot), .cfg_base_hi(cfg_base_hi)
  );

  scanout_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .in_active(in_active), .hs_raw_n(hs_raw_n), .vs_raw_n(vs_raw_n),
    .frame_start(frame_start)
  );

  scanout_fetch #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .HW(HW), .VW(VW), .STRIDE_LOG2(STRIDE_LOG2),
    .BASE_KEEP(BASE_KEEP), .MEM_AW(MEM_AW), .MEM_LAT(MEM_LAT)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .in_active(in_active), .hs_raw_n(hs_raw_n), .vs_raw_n(vs_raw_n),
    .cfg_en(cfg_en), .cfg_rot(cfg_rot), .cfg_base_hi(cfg_base_hi),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .px_rgb(px_rgb), .px_de(px_de),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  assign px_red   = px_rgb[23:16];
  assign px_green = px_rgb[15:8];
  assign px_blue  = px_rgb[7:0];

endmodule

// File: tb/scanout_ctrl_tb.sv
`timescale 1ns/1ps
module scanout_ctrl_tb;
  localparam int H = 8, HFP = 2, HS = 3, HBP = 2;
  localparam int V = 4, VFP = 1, VS = 2, VBP = 2;
  localparam int SL = 4;
  localparam int HTOT = H + HFP + HS + HBP;
  localparam int NPIX = H * V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_rvalid, px_de, hsync_n, vsync_n;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [7:0] px_red, px_green, px_blue;

  always #2.5 clk = ~clk;

  scanout_ctrl #(
    .H_ACT(H), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACT(V), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .STRIDE_LOG2(SL), .BASE_KEEP(11), .MEM_LAT(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .px_red(px_red), .px_green(px_green), .px_blue(px_blue), .px_de(px_de),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return {a[7:0] ^ 8'hF0, a[7:0] ^ 8'h3C, a[15:8] + 8'h11, a[7:0] + a[29:22]};
  endfunction

  function automatic logic [29:0] exp_addr(input logic [31:0] base, input bit rot, input int idx);
    int row, col;
    row = idx / H;
    col = idx % H;
    if (rot) begin
      row = V - 1 - row;
      col = H - 1 - col;
    end
    return 30'((base & 32'hFFE0_0000) >> 2) + 30'(row * (1 << SL) + col);
  endfunction

  // Memory model: fixed two-cycle delay line.
  logic [1:0]  lat_v = '0;
  logic [29:0] lat_a0 = '0, lat_a1 = '0;
  always @(posedge clk) begin
    lat_v  <= {lat_v[0], mem_req};
    lat_a0 <= mem_addr;
    lat_a1 <= lat_a0;
  end
  assign mem_rvalid = lat_v[1];
  assign mem_rdata  = mem_word(lat_a1);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] pend_base = '0, pend_ctrl = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor
  int pix_idx = 0, req_idx = 0, last_pix = -1, last_req = -1;
  logic [31:0] f_base = '0, r_base = '0;
  bit f_rot = 0, r_rot = 0, hs_seen = 0;
  logic hs_prev = 1'b1, vs_prev = 1'b1;
  int hs_period = 0, hs_low = 0, vs_low = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (req_idx == 0) begin r_base = pend_base; r_rot = pend_ctrl[1]; end
        chk(pend_ctrl[0] == 1'b1 || req_idx > 0, "R6", "request while disabled", 32'(mem_req), 32'd0);
        chk(mem_addr == exp_addr(r_base, r_rot, req_idx), r_rot ? "R4" : "R3",
            "request address", 32'(mem_addr), 32'(exp_addr(r_base, r_rot, req_idx)));
        req_idx++;
      end
      if (px_de) begin
        if (pix_idx == 0) begin f_base = pend_base; f_rot = pend_ctrl[1]; end
        chk({px_red, px_green, px_blue} == mem_word(exp_addr(f_base, f_rot, pix_idx))[23:0],
            "R5", "pixel colour (R9 alignment)", {8'h0, px_red, px_green, px_blue},
            {8'h0, mem_word(exp_addr(f_base, f_rot, pix_idx))[23:0]});
        pix_idx++;
      end else begin
        chk({px_red, px_green, px_blue} == 24'h0, "R10", "colour while de low",
            {8'h0, px_red, px_green, px_blue}, 32'h0);
      end
      hs_period++;
      if (!hsync_n) hs_low++;
      if (!vsync_n) vs_low++;
      if (hs_prev && !hsync_n) begin
        if (hs_seen) chk(hs_period == HTOT, "R7", "line period", hs_period, HTOT);
        hs_seen = 1; hs_period = 0;
      end
      if (!hs_prev && hsync_n) begin
        chk(hs_low == HS, "R7", "hsync width", hs_low, HS);
        hs_low = 0;
      end
      if (!vs_prev && vsync_n) begin
        chk(vs_low == VS * HTOT, "R7", "vsync width", vs_low, VS * HTOT);
        vs_low = 0;
      end
      if (vs_prev && !vsync_n) begin
        last_pix = pix_idx; last_req = req_idx;
        pix_idx = 0; req_idx = 0;
      end
      hs_prev = hsync_n;
      vs_prev = vsync_n;
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    if (a == 4'd0) pend_base = d;
    if (a == 4'd4) pend_ctrl = {30'h0, d[1:0]};
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_vs_fall();
    @(negedge vsync_n);
    @(negedge clk);
    #1;
  endtask

  task automatic wait_vs_rise();
    @(posedge vsync_n);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    chk(px_de == 1'b0, "R1", "de in reset", 32'(px_de), 0);
    chk(mem_req == 1'b0, "R1", "request in reset", 32'(mem_req), 0);
    chk({px_red, px_green, px_blue} == 24'h0, "R1", "colour in reset", {8'h0, px_red, px_green, px_blue}, 0);
    chk(hsync_n && vsync_n, "R1", "syncs idle in reset", {30'h0, hsync_n, vsync_n}, 32'h3);
    rst_n = 1'b1;
    reg_read(4'd0, rd); chk(rd == 32'h0, "R1", "base after reset", rd, 0);
    reg_read(4'd4, rd); chk(rd == 32'h0, "R1", "ctrl after reset", rd, 0);
    wait_vs_fall(); wait_vs_fall();
    chk(last_pix == 0, "R1", "pixels while disabled", last_pix, 0);
    chk(last_req == 0, "R6", "requests while disabled", last_req, 0);

    // Register decode and readback
    reg_write(4'd0, 32'hFFFF_FFFF);
    reg_read(4'd0, rd); chk(rd == 32'hFFE0_0000, "R2", "base readback", rd, 32'hFFE0_0000);
    reg_write(4'd4, 32'hFFFF_FFFE);
    reg_read(4'd4, rd); chk(rd == 32'h2, "R2", "ctrl readback", rd, 32'h2);
    reg_write(4'd8, 32'hFFFF_FFFF);
    reg_read(4'd8, rd); chk(rd == 32'h0, "R2", "unmapped read", rd, 0);
    reg_read(4'd4, rd); chk(rd == 32'h2, "R2", "ctrl after unmapped write", rd, 32'h2);
    reg_write(4'd1, 32'h0);
    reg_read(4'd0, rd); chk(rd == 32'hFFE0_0000, "R2", "base after unmapped write", rd, 32'hFFE0_0000);
    reg_write(4'd4, 32'h0);

    // Plain scan
    reg_write(4'd0, 32'h1234_5678);
    reg_write(4'd4, 32'hFFFF_FF01);
    wait_vs_fall(); wait_vs_fall(); wait_vs_fall();
    chk(last_pix == NPIX, "R7", "pixels per frame", last_pix, NPIX);
    chk(last_req == NPIX, "R3", "requests per frame", last_req, NPIX);

    // Mid-frame change: current frame must stay unrotated
    @(posedge px_de); @(negedge clk);
    reg_write(4'd4, 32'h3);
    reg_write(4'd0, 32'h8060_0000);
    wait_vs_fall();
    chk(last_pix == NPIX, "R8", "frame completes after mid-frame write", last_pix, NPIX);
    wait_vs_fall();
    chk(last_pix == NPIX, "R4", "rotated frame pixels", last_pix, NPIX);
    chk(last_req == NPIX, "R4", "rotated frame requests", last_req, NPIX);

    // Disable in back porch
    wait_vs_rise();
    reg_write(4'd4, 32'h0);
    wait_vs_fall();
    chk(last_pix == 0, "R6", "pixels after disable", last_pix, 0);
    chk(last_req == 0, "R6", "requests after disable", last_req, 0);

    // Re-enable with highest base, unrotated
    wait_vs_rise();
    reg_write(4'd0, 32'hFFE0_0000);
    reg_write(4'd4, 32'h1);
    wait_vs_fall();
    chk(last_pix == NPIX, "R3", "frame at top base", last_pix, NPIX);

    // Rotated at base zero
    wait_vs_rise();
    reg_write(4'd0, 32'h001F_FFFF);
    reg_write(4'd4, 32'h3);
    wait_vs_fall();
    chk(last_pix == NPIX, "R4", "rotated frame at base zero", last_pix, NPIX);
    chk(last_req == NPIX, "R8", "requests after back-porch write", last_req, NPIX);

    repeat (10) @(negedge clk);
    finish_up();
  end

endmodule